// File: doc/BRIEF.md
# Watchpoint Action Gate

This block stands between the raw hit pulses of a set of debug watchpoint channels and the logic that acts on those hits. That logic includes the event handler launcher, the event counters, the chain latches, the trigger-out pin and the trace unit. Each channel has a precondition enable and a five-bit action mask. A channel acts only when it hits, its precondition holds, and the relevant action bit is set. The result is one registered strobe per channel for each action kind.

One watch-enable bit covers a fixed group of channels. These are the instruction-address, operand-address, instruction-value, branch and performance channels. When the bit is low, every action of that group is voided. The remaining channels (software breakpoint, two auxiliary channels and the debug-module channel) pass through on their own masks alone.

The watch-enable bit is held in a two-state machine. Its states are WS_QUIET (bit low) and WS_ARMED (bit high). The transitions are named below:

- LAUNCH: a handler launch strobe moves any state to WS_QUIET.
- RESTORE: a return from exception loads the saved status value.
- SWWRITE: a software status write loads the written value.
- HOLD: with none of these events, the state stays put.

The priority is LAUNCH over RESTORE over SWWRITE. A separate snapshot keeps the watch value from before the most recent return. A branch hit caused by that return is gated by the snapshot, so a return that turns watching back on never catches its own branch.

Top module: `wpg_action_gate`

## Requirements
- R1: After reset the watch-enable output is 0, every precondition enable and action mask is 0, and all action outputs are 0.
- R2: A channel produces actions only when its match input is 1 and its precondition is met. The precondition is met when the precondition enable is 0 or pre_ok is 1. The outputs appear one cycle after the match. Action bit 0 drives out_launch_o, bit 1 out_count_o, bit 2 out_chain_o, bit 3 out_trig_o and bit 4 out_trace_o, each at the bit position equal to the channel index.
- R3: Channels 0 to 4 are gated: 0 instruction address, 1 operand address, 2 instruction value, 3 branch, 4 performance. While the watch-enable bit is 0, all their actions are suppressed. Channels 5 to 8 behave the same whatever the watch-enable bit is.
- R4: Any of the three launch strobes drives the watch-enable bit to 0 in the next cycle. This wins over a simultaneous return or software write. A match in the launch cycle still uses the old value.
- R5: A return strobe without a launch loads the saved watch value in the next cycle. It wins over a simultaneous software write.
- R6: A software status write without a launch or return updates the watch-enable bit in the next cycle. A match in the write cycle uses the old value. With no event, the bit holds.
- R7: A branch-channel match flagged as caused by a return is gated by the watch value before that return, whether it arrives in the return cycle or later. Unflagged matches and all other channels use the current value.
- R8: A configuration write takes effect from the next cycle. A write whose channel index is 9 or above changes no channel.
- R9: Several channels matching in one cycle each produce their own actions independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| match_i | input | 9 | Per-channel match pulse |
| pre_ok_i | input | 9 | Per-channel precondition satisfied |
| br_from_rte_i | input | 1 | Branch match is the branch of a return from exception |
| launch_i | input | 3 | Handler launch strobes (reset, panic, debug) |
| rte_i | input | 1 | Return-from-exception strobe |
| rte_saved_watch_i | input | 1 | Watch bit in the saved status word |
| sr_wr_i | input | 1 | Software status write strobe |
| sr_wr_watch_i | input | 1 | Watch bit of the written status word |
| cfg_wr_i | input | 1 | Mask configuration write strobe |
| cfg_ch_i | input | 4 | Channel index of the configuration write |
| cfg_pre_en_i | input | 1 | Precondition enable to store |
| cfg_act_i | input | 5 | Action mask to store |
| watch_o | output | 1 | Current watch-enable bit |
| out_launch_o | output | 9 | Handler launch requests per channel |
| out_count_o | output | 9 | Counter increments per channel |
| out_chain_o | output | 9 | Chain latch sets per channel |
| out_trig_o | output | 9 | Trigger-out pulses per channel |
| out_trace_o | output | 9 | Trace requests per channel |

## Verification
The hardest situation to reach is a branch hit belonging to a return that flips the watch bit. The match must see the pre-return value while the status bit already shows the new one. The stimulus first puts the bit into a known state through a launch or a software write. It then issues a return carrying the opposite saved value, and presents flagged and unflagged branch hits both in the return cycle and in the cycle after. A gated neighbour channel is driven alongside as a contrast. The plain gating is covered by an exhaustive sweep over every channel, both watch values and all match and precondition combinations.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    localparam int NUM_ACT    = 5;
    localparam int ACT_LAUNCH = 0;
    localparam int ACT_COUNT  = 1;
    localparam int ACT_CHAIN  = 2;
    localparam int ACT_TRIG   = 3;
    localparam int ACT_TRACE  = 4;

    typedef enum logic {
        WS_QUIET = 1'b0,
        WS_ARMED = 1'b1
    } wstate_t;
endpackage

// File: rtl/wpg_watch_fsm.sv
module wpg_watch_fsm
    import wpg_pkg::*;
#(
    parameter int NUM_LAUNCH = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_LAUNCH-1:0] launch_i,
    input  logic                  rte_i,
    input  logic                  rte_saved_i,
    input  logic                  sr_wr_i,
    input  logic                  sr_data_i,
    output logic                  watch_o,
    output logic                  pre_rte_o
);
    wstate_t state_q, state_d;
    logic    any_launch;
    logic    pre_rte_q;

    assign any_launch = |launch_i;

    // next-state: LAUNCH > RESTORE > SWWRITE > HOLD
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_QUIET: begin
                if (any_launch)                        state_d = WS_QUIET;
                else if (rte_i && rte_saved_i)         state_d = WS_ARMED;
                else if (!rte_i && sr_wr_i && sr_data_i) state_d = WS_ARMED;
            end
            WS_ARMED: begin
                if (any_launch)                         state_d = WS_QUIET;
                else if (rte_i && !rte_saved_i)         state_d = WS_QUIET;
                else if (!rte_i && sr_wr_i && !sr_data_i) state_d = WS_QUIET;
            end
            default: state_d = WS_QUIET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= WS_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        watch_o   = (state_q == WS_ARMED);
        pre_rte_o = pre_rte_q;
    end

    // snapshot of the watch value taken at the start of each return
    always_ff @(posedge clk) begin
        if (!rst_n)     pre_rte_q <= 1'b0;
        else if (rte_i) pre_rte_q <= watch_o;
    end

    // R4
    launch_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_launch |=> !watch_o);

    // R5
    rte_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_i && !any_launch) |=> (watch_o == $past(rte_saved_i)));

    // R6
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sr_wr_i && !rte_i && !any_launch) |=> (watch_o == $past(sr_data_i)));

    // R6
    watch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sr_wr_i && !rte_i && !any_launch) |=> $stable(watch_o));

    // R7
    snapshot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rte_i |=> (pre_rte_o == $past(watch_o)));
endmodule

// File: rtl/wpg_mask_bank.sv
module wpg_mask_bank
    import wpg_pkg::*;
#(
    parameter int NUM_CH = 9,
    parameter int CH_W   = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_wr_i,
    input  logic [CH_W-1:0]           cfg_ch_i,
    input  logic                      cfg_pre_en_i,
    input  logic [NUM_ACT-1:0]        cfg_act_i,
    output logic [NUM_CH-1:0]         pre_en_o,
    output logic [NUM_CH*NUM_ACT-1:0] act_mask_o
);
    logic in_range;
    assign in_range = (int'(cfg_ch_i) < NUM_CH);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_slot
        logic sel;
        assign sel = cfg_wr_i && in_range && (int'(cfg_ch_i) == c);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pre_en_o[c]                        <= 1'b0;
                act_mask_o[c*NUM_ACT +: NUM_ACT]   <= '0;
            end else if (sel) begin
                pre_en_o[c]                        <= cfg_pre_en_i;
                act_mask_o[c*NUM_ACT +: NUM_ACT]   <= cfg_act_i;
            end
        end
    end

    // R8
    oob_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr_i && !in_range) |=> ($stable(act_mask_o) && $stable(pre_en_o)));

    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_wr_i |=> ($stable(act_mask_o) && $stable(pre_en_o)));
endmodule

// File: rtl/wpg_chan_gate.sv
module wpg_chan_gate
    import wpg_pkg::*;
#(
    parameter bit GATED = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               match_i,
    input  logic               pre_ok_i,
    input  logic               pre_en_i,
    input  logic [NUM_ACT-1:0] act_mask_i,
    input  logic               we_eff_i,
    output logic [NUM_ACT-1:0] act_o
);
    logic fire;
    logic [NUM_ACT-1:0] act_q;

    assign fire = match_i && (!pre_en_i || pre_ok_i) && (!GATED || we_eff_i);

    always_ff @(posedge clk) begin
        if (!rst_n)    act_q <= '0;
        else if (fire) act_q <= act_mask_i;
        else           act_q <= '0;
    end

    assign act_o = act_q;

    // R2
    act_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_q) |-> ($past(match_i) && (!$past(pre_en_i) || $past(pre_ok_i))));

    // R2
    act_in_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_q) |-> ((act_q & ~$past(act_mask_i)) == '0));

    if (GATED) begin : g_gated_chk
        // R3
        gated_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !we_eff_i |=> (act_q == '0));
    end
endmodule

// File: rtl/wpg_action_gate.sv
module wpg_action_gate
    import wpg_pkg::*;
#(
    parameter int              NUM_CH     = 9,
    parameter logic [NUM_CH-1:0] GATED_SET = 9'h01F,
    parameter int              BR_CH      = 3,
    parameter int              NUM_LAUNCH = 3,
    localparam int             CH_W       = $clog2(NUM_CH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     match_i,
    input  logic [NUM_CH-1:0]     pre_ok_i,
    input  logic                  br_from_rte_i,
    input  logic [NUM_LAUNCH-1:0] launch_i,
    input  logic                  rte_i,
    input  logic                  rte_saved_watch_i,
    input  logic                  sr_wr_i,
    input  logic                  sr_wr_watch_i,
    input  logic                  cfg_wr_i,
    input  logic [CH_W-1:0]       cfg_ch_i,
    input  logic                  cfg_pre_en_i,
    input  logic [NUM_ACT-1:0]    cfg_act_i,
    output logic                  watch_o,
    output logic [NUM_CH-1:0]     out_launch_o,
    output logic [NUM_CH-1:0]     out_count_o,
    output logic [NUM_CH-1:0]     out_chain_o,
    output logic [NUM_CH-1:0]     out_trig_o,
    output logic [NUM_CH-1:0]     out_trace_o
);
    logic                      watch;
    logic                      pre_rte;
    logic [NUM_CH-1:0]         pre_en;
    logic [NUM_CH*NUM_ACT-1:0] act_mask;
    logic                      br_watch;

    wpg_watch_fsm #(.NUM_LAUNCH(NUM_LAUNCH)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch_i    (launch_i),
        .rte_i       (rte_i),
        .rte_saved_i (rte_saved_watch_i),
        .sr_wr_i     (sr_wr_i),
        .sr_data_i   (sr_wr_watch_i),
        .watch_o     (watch),
        .pre_rte_o   (pre_rte)
    );

    wpg_mask_bank #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_masks (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_i     (cfg_wr_i),
        .cfg_ch_i     (cfg_ch_i),
        .cfg_pre_en_i (cfg_pre_en_i),
        .cfg_act_i    (cfg_act_i),
        .pre_en_o     (pre_en),
        .act_mask_o   (act_mask)
    );

    // branch of a return: value before the return (live value in the return cycle)
    assign br_watch = br_from_rte_i ? (rte_i ? watch : pre_rte) : watch;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic               we_eff;
        logic [NUM_ACT-1:0] act;

        if (c == BR_CH) begin : g_br
            assign we_eff = br_watch;
        end else begin : g_plain
            assign we_eff = watch;
        end

        wpg_chan_gate #(.GATED(GATED_SET[c])) u_gate (
            .clk        (clk),
            .rst_n      (rst_n),
            .match_i    (match_i[c]),
            .pre_ok_i   (pre_ok_i[c]),
            .pre_en_i   (pre_en[c]),
            .act_mask_i (act_mask[c*NUM_ACT +: NUM_ACT]),
            .we_eff_i   (we_eff),
            .act_o      (act)
        );

        assign out_launch_o[c] = act[ACT_LAUNCH];
        assign out_count_o[c]  = act[ACT_COUNT];
        assign out_chain_o[c]  = act[ACT_CHAIN];
        assign out_trig_o[c]   = act[ACT_TRIG];
        assign out_trace_o[c]  = act[ACT_TRACE];
    end

    assign watch_o = watch;

    // R7
    br_rte_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (br_from_rte_i && !rte_i && !pre_rte) |=> !(out_launch_o[BR_CH] || out_count_o[BR_CH]
            || out_chain_o[BR_CH] || out_trig_o[BR_CH] || out_trace_o[BR_CH]));

    // R3
    group_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!watch && !br_from_rte_i) |=> (((out_launch_o | out_count_o | out_chain_o
            | out_trig_o | out_trace_o) & GATED_SET) == '0));
endmodule

// File: tb/test_wpg_action_gate.sv
module test_wpg_action_gate;
    localparam int NC = 9;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NC-1:0] match_i, pre_ok_i;
    logic          br_from_rte_i;
    logic [2:0]    launch_i;
    logic          rte_i, rte_saved_watch_i, sr_wr_i, sr_wr_watch_i;
    logic          cfg_wr_i, cfg_pre_en_i;
    logic [3:0]    cfg_ch_i;
    logic [4:0]    cfg_act_i;
    logic          watch_o;
    logic [NC-1:0] out_launch_o, out_count_o, out_chain_o, out_trig_o, out_trace_o;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wpg_action_gate i_wpg_action_gate (
        .clk(clk), .rst_n(rst_n), .match_i(match_i), .pre_ok_i(pre_ok_i),
        .br_from_rte_i(br_from_rte_i), .launch_i(launch_i), .rte_i(rte_i),
        .rte_saved_watch_i(rte_saved_watch_i), .sr_wr_i(sr_wr_i),
        .sr_wr_watch_i(sr_wr_watch_i), .cfg_wr_i(cfg_wr_i), .cfg_ch_i(cfg_ch_i),
        .cfg_pre_en_i(cfg_pre_en_i), .cfg_act_i(cfg_act_i), .watch_o(watch_o),
        .out_launch_o(out_launch_o), .out_count_o(out_count_o),
        .out_chain_o(out_chain_o), .out_trig_o(out_trig_o), .out_trace_o(out_trace_o)
    );

    function automatic logic [5*NC-1:0] actual();
        return {out_trace_o, out_trig_o, out_chain_o, out_count_o, out_launch_o};
    endfunction

    function automatic logic [5*NC-1:0] expv(int ch, logic [4:0] a);
        logic [5*NC-1:0] e = '0;
        for (int k = 0; k < 5; k++) if (a[k]) e[k*NC+ch] = 1'b1;
        return e;
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        match_i = '0; pre_ok_i = '0; br_from_rte_i = 1'b0; launch_i = '0;
        rte_i = 1'b0; rte_saved_watch_i = 1'b0; sr_wr_i = 1'b0; sr_wr_watch_i = 1'b0;
        cfg_wr_i = 1'b0; cfg_ch_i = '0; cfg_pre_en_i = 1'b0; cfg_act_i = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    task automatic cfg(int ch, logic pe, logic [4:0] a);
        cfg_wr_i = 1'b1; cfg_ch_i = 4'(ch); cfg_pre_en_i = pe; cfg_act_i = a;
        tick();
    endtask

    task automatic set_watch(logic v);
        sr_wr_i = 1'b1; sr_wr_watch_i = v;
        tick();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        idle();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 watch", 64'(watch_o), 64'd0);
        chk("R1 outputs", 64'(actual()), 64'd0);
        set_watch(1'b1);
        match_i = '1; pre_ok_i = '1;
        tick();
        chk("R1 masks cleared", 64'(actual()), 64'd0);

        // R2 R3 exhaustive sweep
        for (int w = 0; w < 2; w++) begin
            set_watch(w[0]);
            for (int ch = 0; ch < NC; ch++) begin
                for (int cb = 0; cb < 8; cb++) begin
                    logic m, pe, po, f;
                    logic [4:0] a;
                    m = cb[0]; pe = cb[1]; po = cb[2];
                    a = 5'((ch * 7 + cb + 1) % 31 + 1);
                    cfg(ch, pe, a);
                    match_i[ch] = m; pre_ok_i[ch] = po;
                    tick();
                    f = m && (!pe || po) && (ch > 4 || w == 1);
                    chk("R2 R3 sweep", 64'(actual()), 64'(f ? expv(ch, a) : '0));
                end
            end
        end

        // R6 write-cycle match sees old value
        for (int c = 0; c < NC; c++) cfg(c, 1'b0, 5'b00001);
        set_watch(1'b0);
        sr_wr_i = 1'b1; sr_wr_watch_i = 1'b1; match_i[0] = 1'b1;
        tick();
        chk("R6 old value in write cycle", 64'(actual()), 64'd0);
        chk("R6 watch updated", 64'(watch_o), 64'd1);
        match_i[0] = 1'b1;
        tick();
        chk("R6 new value used", 64'(actual()), 64'(expv(0, 5'b00001)));
        tick();
        chk("R6 hold", 64'(watch_o), 64'd1);

        // R4 each launch strobe clears; launch-cycle match uses old value
        for (int l = 0; l < 3; l++) begin
            set_watch(1'b1);
            launch_i = 3'(1 << l); match_i[1] = 1'b1;
            tick();
            chk("R4 launch-cycle match", 64'(actual()), 64'(expv(1, 5'b00001)));
            chk("R4 launch clears", 64'(watch_o), 64'd0);
        end
        set_watch(1'b1);
        launch_i = 3'b100; rte_i = 1'b1; rte_saved_watch_i = 1'b1;
        tick();
        chk("R4 launch beats return", 64'(watch_o), 64'd0);
        launch_i = 3'b001; sr_wr_i = 1'b1; sr_wr_watch_i = 1'b1;
        tick();
        chk("R4 launch beats write", 64'(watch_o), 64'd0);

        // R5 return restores; beats software write
        rte_i = 1'b1; rte_saved_watch_i = 1'b1;
        tick();
        chk("R5 restore to 1", 64'(watch_o), 64'd1);
        rte_i = 1'b1; rte_saved_watch_i = 1'b0; sr_wr_i = 1'b1; sr_wr_watch_i = 1'b1;
        tick();
        chk("R5 return beats write", 64'(watch_o), 64'd0);

        // R7 branch of return sees pre-return value
        cfg(3, 1'b0, 5'b11111);
        cfg(0, 1'b0, 5'b11111);
        launch_i = 3'b010;
        tick();
        rte_i = 1'b1; rte_saved_watch_i = 1'b1; match_i[3] = 1'b1; br_from_rte_i = 1'b1;
        tick();
        chk("R7 branch in return cycle gated", 64'(actual()), 64'd0);
        match_i[3] = 1'b1; br_from_rte_i = 1'b1; match_i[0] = 1'b1;
        tick();
        chk("R7 flagged branch after return gated", 64'(actual()), 64'(expv(0, 5'b11111)));
        match_i[3] = 1'b1;
        tick();
        chk("R7 unflagged branch uses current", 64'(actual()), 64'(expv(3, 5'b11111)));
        rte_i = 1'b1; rte_saved_watch_i = 1'b0;
        tick();
        chk("R7 watch cleared by return", 64'(watch_o), 64'd0);
        match_i[3] = 1'b1; br_from_rte_i = 1'b1; match_i[0] = 1'b1;
        tick();
        chk("R7 flagged branch uses pre-return 1", 64'(actual()), 64'(expv(3, 5'b11111)));

        // R8 out-of-range config ignored, write takes effect next cycle
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1;
        for (int c = NC; c < 16; c++) cfg(c, 1'b0, 5'b11111);
        set_watch(1'b1);
        match_i = '1; pre_ok_i = '1;
        tick();
        chk("R8 out-of-range ignored", 64'(actual()), 64'd0);
        cfg_wr_i = 1'b1; cfg_ch_i = 4'd5; cfg_act_i = 5'b10101; match_i[5] = 1'b1;
        tick();
        chk("R8 write-cycle uses old mask", 64'(actual()), 64'd0);
        match_i[5] = 1'b1;
        tick();
        chk("R8 new mask used", 64'(actual()), 64'(expv(5, 5'b10101)));

        // R9 simultaneous channels
        for (int c = 0; c < NC; c++) cfg(c, c[0], 5'((c * 3 + 2) % 31 + 1));
        for (int w = 0; w < 2; w++) begin
            logic [5*NC-1:0] e;
            set_watch(w[0]);
            e = '0;
            for (int c = 0; c < NC; c++)
                if (c > 4 || w == 1) e = e | expv(c, 5'((c * 3 + 2) % 31 + 1));
            match_i = '1; pre_ok_i = '1;
            tick();
            chk("R9 all channels", 64'(actual()), 64'(e));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule